// File: doc/BRIEF.md
# Edge Interrupt Pulse Shaper

The block turns an internal interrupt request into the signal that leaves the chip on its interrupt pin. In edge mode every accepted request becomes a high pulse whose length is a programmable number of clock cycles. After each pulse a programmable quiet interval must pass before the next pulse may start. That interval is counted in start-of-frame ticks, where one tick marks a 125 µs microframe, and not in clock cycles. Requests that arrive while a pulse or a quiet interval is in progress are kept in a single pending flag. They are released together as one pulse once the interval has run out.

In level mode the pin simply shows the pending flag, and the quiet interval plays no part. The flag is set by a request strobe and dropped by a clear strobe. Both counts sit in one 32-bit configuration word that is loaded through a write strobe. Reset gives a pulse of 62 cycles, which is about 500 ns at 125 MHz, and a quiet interval of zero.

Top module: `irq_pulse_shaper`

## Requirements
- R1: After a synchronous active-low reset, `irq_o` and `pending_o` are low, the pulse length is 62 cycles and the quiet interval is 0 ticks.
- R2: A cycle with `cfg_we_i` high loads the pulse length from `cfg_wdata_i[31:16]` and the quiet interval from `cfg_wdata_i[7:0]`, effective from the next cycle; bits [15:8] are reserved and have no effect.
- R3: `evt_i` high at a clock edge sets `pending_o` after that edge; in edge mode with no pulse or interval running, `irq_o` rises one edge later.
- R4: In edge mode a pulse stays high for exactly the programmed number of cycles; a programmed length of 0 gives a one-cycle pulse.
- R5: With a quiet interval of 0, a request held pending during a pulse starts the next pulse after exactly one low cycle.
- R6: With a quiet interval of G > 0, the next pulse waits until G `sof_i` ticks have been sampled after the pulse ended; ticks during the pulse are not counted, and the pulse starts on the edge after the G-th tick.
- R7: Any number of requests that arrive during a pulse or a quiet interval produce exactly one further pulse.
- R8: With `level_mode_i` high, `irq_o` equals `pending_o` and stays high, whatever the ticks, until the flag is cleared.
- R9: `evt_clr_i` clears the pending flag in either mode; if `evt_i` is high in the same cycle, the flag ends up set.
- R10: In edge mode the pending flag drops on the edge at which a pulse starts, unless `evt_i` is high at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | 1 | Interrupt request strobe |
| evt_clr_i | input | 1 | Clears the pending request |
| sof_i | input | 1 | One-cycle microframe tick |
| level_mode_i | input | 1 | 1 = level signalling, 0 = edge pulses |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration word: [31:16] pulse length, [15:8] reserved, [7:0] quiet interval |
| irq_o | output | 1 | Interrupt pin |
| pending_o | output | 1 | Pending request flag |

## Verification
The bench aims at a length of zero and at requests that fall inside a pulse. A design without the zero clamp would hold the pin for 65,536 cycles, and one without the pending flag would lose or repeat a pulse. It times the quiet interval against the exact tick that ends it, which exposes a design that counts ticks seen during the pulse or ends the interval one tick early. It also checks the reserved byte, a clear in the middle of an interval, set and clear in the same cycle, and level mode over many ticks, where a shaper that still applied its timers would drop the pin.

// File: rtl/ips_pkg.sv
// Package: shared types for the interrupt pulse shaper.
// Assumes: nothing beyond a single clock domain.
package ips_pkg;

    // Sequencer phases of the edge-mode output.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_GAP   = 2'd2
    } state_e;

endpackage

// File: rtl/ips_downcnt.sv
// Module: loadable down counter used for both pulse length and quiet interval.
// Assumes: the owner never asks for a decrement while the count is zero.
module ips_downcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic [W-1:0] count_o
);

    logic [W-1:0] cnt_q;

    // Load takes priority over decrement; reset clears the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count_o = cnt_q;

    // The sequencer must never walk a counter below zero (R4, R6).
    p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i) |-> (count_o != '0));

endmodule

// File: rtl/ips_cfg_reg.sv
// Module: holds the pulse-length and quiet-interval fields of the config word.
// Assumes: word layout is [interval | reserved | length] from the low bit up.
module ips_cfg_reg #(
    parameter int PULSE_W   = 16,
    parameter int GAP_W     = 8,
    parameter int RSV_W     = 8,
    parameter int PULSE_RST = 62,
    parameter int WORD_W    = GAP_W + RSV_W + PULSE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [WORD_W-1:0]  wdata_i,
    output logic [PULSE_W-1:0] width_o,
    output logic [GAP_W-1:0]   gap_o
);

    localparam int WID_LSB = GAP_W + RSV_W;

    logic [PULSE_W-1:0] width_q;
    logic [GAP_W-1:0]   gap_q;
    logic               rsv_unused;

    // Reserved byte is accepted on the bus but stored nowhere.
    assign rsv_unused = ^wdata_i[WID_LSB-1:GAP_W];

    // Capture both fields on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q <= PULSE_W'(PULSE_RST);
            gap_q   <= '0;
        end else if (we_i) begin
            width_q <= wdata_i[WID_LSB +: PULSE_W];
            gap_q   <= wdata_i[0 +: GAP_W];
        end
    end

    assign width_o = width_q;
    assign gap_o   = gap_q;

    // A written word shows up in the fields one cycle later (R2).
    p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (gap_o == $past(wdata_i[0 +: GAP_W])));

endmodule

// File: rtl/ips_pending.sv
// Module: single-bit pending request flag; merges any number of requests.
// Assumes: launch_i comes from the sequencer and is only high in edge mode.
module ips_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic clr_i,
    input  logic launch_i,
    output logic pend_o
);

    logic pend_q;

    // A new request wins over the clear and over consumption by a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (evt_i) begin
            pend_q <= 1'b1;
        end else if (clr_i || launch_i) begin
            pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    // A request is never lost, even next to a clear (R3, R9).
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> pend_o);

    // A clear without a request empties the flag (R9).
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !evt_i) |=> !pend_o);

endmodule

// File: rtl/ips_seq.sv
// Module: edge-mode sequencer; runs the pulse timer, then the tick-based
//         quiet interval, and starts a pulse when a request is pending.
// Assumes: sof_i is a one-cycle strobe in this clock domain.
module ips_seq #(
    parameter int PULSE_W = 16,
    parameter int GAP_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               level_i,
    input  logic               pend_i,
    input  logic               sof_i,
    input  logic [PULSE_W-1:0] width_i,
    input  logic [GAP_W-1:0]   gap_i,
    output logic               launch_o,
    output logic               pulse_o
);
    import ips_pkg::*;

    state_e             state_q, state_d;
    logic [PULSE_W-1:0] pcnt;
    logic [GAP_W-1:0]   gcnt;
    logic [PULSE_W-1:0] pload;
    logic               pulse_last;
    logic               gap_load;
    logic               gap_last;

    // Pulse counter holds the remaining high cycles minus one; 0 means one cycle.
    assign pload      = (width_i == '0) ? '0 : (width_i - 1'b1);
    assign pulse_last = (state_q == ST_PULSE) && (pcnt == '0);
    assign gap_load   = !level_i && pulse_last && (gap_i != '0);
    assign gap_last   = (state_q == ST_GAP) && sof_i && (gcnt == GAP_W'(1));
    assign launch_o   = !level_i && (state_q == ST_IDLE) && pend_i;

    ips_downcnt #(.W(PULSE_W)) u_pulse_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (launch_o),
        .load_val_i (pload),
        .dec_i      ((state_q == ST_PULSE) && (pcnt != '0)),
        .count_o    (pcnt)
    );

    ips_downcnt #(.W(GAP_W)) u_gap_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (gap_load),
        .load_val_i (gap_i),
        .dec_i      ((state_q == ST_GAP) && sof_i && (gcnt != GAP_W'(1))),
        .count_o    (gcnt)
    );

    // Next phase; level mode parks the sequencer.
    always_comb begin
        state_d = state_q;
        if (level_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (pend_i)     state_d = ST_PULSE;
                ST_PULSE: if (pulse_last) state_d = (gap_i == '0) ? ST_IDLE : ST_GAP;
                ST_GAP:   if (gap_last)   state_d = ST_IDLE;
                default:                  state_d = ST_IDLE;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign pulse_o = (state_q == ST_PULSE);

    // A pulse with cycles left keeps running (R4).
    p_pulse_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_i && (state_q == ST_PULSE) && (pcnt != '0)) |=> (state_q == ST_PULSE));

    // Without a tick the quiet interval cannot end (R6).
    p_gap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_i && (state_q == ST_GAP) && !sof_i) |=> (state_q == ST_GAP));

    // An interval is only entered from the last pulse cycle (R6).
    p_gap_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_GAP) && (state_d == ST_GAP)) |-> pulse_last);

endmodule

// File: rtl/irq_pulse_shaper.sv
// Module: top of the interrupt pulse shaper. Edge mode drives the pin from the
//         sequencer; level mode drives it from the pending flag.
// Assumes: all inputs synchronous to clk; reserved config bits written as zero.
module irq_pulse_shaper #(
    parameter int PULSE_W   = 16,
    parameter int GAP_W     = 8,
    parameter int RSV_W     = 8,
    parameter int PULSE_RST = 62,
    localparam int WORD_W   = GAP_W + RSV_W + PULSE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_i,
    input  logic              evt_clr_i,
    input  logic              sof_i,
    input  logic              level_mode_i,
    input  logic              cfg_we_i,
    input  logic [WORD_W-1:0] cfg_wdata_i,
    output logic              irq_o,
    output logic              pending_o
);

    logic [PULSE_W-1:0] width;
    logic [GAP_W-1:0]   gap;
    logic               pend;
    logic               launch;
    logic               pulse;

    ips_cfg_reg #(
        .PULSE_W   (PULSE_W),
        .GAP_W     (GAP_W),
        .RSV_W     (RSV_W),
        .PULSE_RST (PULSE_RST)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_wdata_i),
        .width_o (width),
        .gap_o   (gap)
    );

    ips_pending u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .clr_i    (evt_clr_i),
        .launch_i (launch),
        .pend_o   (pend)
    );

    ips_seq #(
        .PULSE_W (PULSE_W),
        .GAP_W   (GAP_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_i  (level_mode_i),
        .pend_i   (pend),
        .sof_i    (sof_i),
        .width_i  (width),
        .gap_i    (gap),
        .launch_o (launch),
        .pulse_o  (pulse)
    );

    // Pin select: pending flag in level mode, sequencer pulse in edge mode.
    assign irq_o     = level_mode_i ? pend : pulse;
    assign pending_o = pend;

    // An edge pulse only starts from a pending request (R3).
    p_rise_needs_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode_i && $past(!level_mode_i) && $rose(irq_o)) |-> $past(pending_o));

    // Starting a pulse consumes the request unless a new one came in (R10).
    p_launch_consumes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode_i && $past(!level_mode_i) && $rose(irq_o) && !$past(evt_i))
            |-> !pending_o);

endmodule

// File: tb/irq_pulse_shaper_tb.sv
// Bench: behavioural reference model compared on every clock, plus directed
//        checks on pulse timing recorded from the pin.
module irq_pulse_shaper_tb_top;

    localparam int PW_RST  = 62;
    localparam int SOF_PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt = 1'b0;
    logic        clr = 1'b0;
    logic        sof = 1'b0;
    logic        lvl = 1'b0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic        irq_o;
    logic        pending_o;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    chk_on = 1'b0;
    bit    sof_en = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference model state
    bit m_pend;
    bit m_launch;
    int m_phase;
    int m_left;
    int m_gleft;
    int m_w;
    int m_g;

    int rise_q[$];
    int fall_q[$];
    int sof_q[$];
    bit prev_irq = 1'b0;

    irq_pulse_shaper dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (evt),
        .evt_clr_i    (clr),
        .sof_i        (sof),
        .level_mode_i (lvl),
        .cfg_we_i     (we),
        .cfg_wdata_i  (wdata),
        .irq_o        (irq_o),
        .pending_o    (pending_o)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference model, then a comparison once the outputs have settled.
    always @(posedge clk) begin
        int exp_irq;
        cyc++;
        if (!rst_n) begin
            m_pend = 0; m_phase = 0; m_left = 0; m_gleft = 0;
            m_w = PW_RST; m_g = 0;
        end else begin
            m_launch = !lvl && m_phase == 0 && m_pend;
            if (lvl) m_phase = 0;
            else case (m_phase)
                0: if (m_pend) begin m_phase = 1; m_left = (m_w == 0) ? 1 : m_w; end
                1: begin
                    m_left--;
                    if (m_left == 0) begin
                        if (m_g == 0) m_phase = 0;
                        else begin m_phase = 2; m_gleft = m_g; end
                    end
                end
                default: if (sof) begin
                    m_gleft--;
                    if (m_gleft == 0) m_phase = 0;
                end
            endcase
            if (evt) m_pend = 1;
            else if (clr || m_launch) m_pend = 0;
            if (we) begin m_w = int'(wdata[31:16]); m_g = int'(wdata[7:0]); end
        end
        #2;
        if (chk_on) begin
            exp_irq = lvl ? int'(m_pend) : int'(m_phase == 1);
            n_chk++;
            if (irq_o !== exp_irq[0] || pending_o !== m_pend) begin
                n_fail++;
                $display("FAIL %s model cycle %0d: actual irq=%b pend=%b expected irq=%0d pend=%0d",
                         cur_req, cyc, irq_o, pending_o, exp_irq, m_pend);
            end
        end
    end

    // Pin edge recorder.
    always @(negedge clk) begin
        if (irq_o === 1'b1 && !prev_irq) rise_q.push_back(cyc);
        if (irq_o !== 1'b1 && prev_irq)  fall_q.push_back(cyc);
        prev_irq = (irq_o === 1'b1);
    end

    // Microframe tick generator.
    always @(negedge clk) begin
        if (sof_en && (cyc % SOF_PER == 0)) begin
            sof <= 1'b1;
            sof_q.push_back(cyc);
        end else begin
            sof <= 1'b0;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input int w, input int g, input int rsv);
        we = 1'b1;
        wdata = {w[15:0], rsv[7:0], g[7:0]};
        @(negedge clk);
        we = 1'b0;
        wdata = '0;
    endtask

    task automatic fire();
        evt = 1'b1;
        @(negedge clk);
        evt = 1'b0;
    endtask

    task automatic clear_log();
        rise_q.delete();
        fall_q.delete();
        sof_q.delete();
    endtask

    task automatic check_single_len(input string req, input int exp_len);
        check(req, "pulse count", rise_q.size(), 1);
        if (rise_q.size() == 1 && fall_q.size() == 1)
            check(req, "pulse length", fall_q[0] - rise_q[0], exp_len);
    endtask

    initial begin
        int nsof;
        bit last_tick;
        tick(1);
        chk_on = 1'b1;
        tick(2);
        // R1: reset state
        cur_req = "R1";
        check("R1", "irq in reset", int'(irq_o), 0);
        check("R1", "pending in reset", int'(pending_o), 0);
        rst_n = 1'b1;
        tick(2);

        // R3, R10, R1: first request with reset length
        cur_req = "R3";
        clear_log();
        fire();
        check("R3", "pending after request", int'(pending_o), 1);
        check("R3", "irq before launch", int'(irq_o), 0);
        tick(1);
        check("R3", "irq after launch", int'(irq_o), 1);
        check("R10", "pending consumed at launch", int'(pending_o), 0);
        tick(80);
        check_single_len("R1", PW_RST);

        // R2: new length, reserved byte all ones
        cur_req = "R2";
        write_cfg(5, 0, 8'hFF);
        clear_log();
        fire();
        tick(20);
        check_single_len("R2", 5);

        // R4: length zero gives one cycle
        cur_req = "R4";
        write_cfg(0, 0, 0);
        clear_log();
        fire();
        tick(10);
        check_single_len("R4", 1);

        // R5, R7: requests during pulse, no interval
        cur_req = "R5";
        write_cfg(3, 0, 0);
        clear_log();
        fire();
        tick(1);
        fire();
        fire();
        tick(60);
        check("R7", "merged pulse count", rise_q.size(), 2);
        if (rise_q.size() == 2 && fall_q.size() == 2) begin
            check("R4", "first length", fall_q[0] - rise_q[0], 3);
            check("R5", "low cycles between", rise_q[1] - fall_q[0], 1);
            check("R4", "second length", fall_q[1] - rise_q[1], 3);
        end

        // R6, R7: interval of 3 ticks
        cur_req = "R6";
        write_cfg(4, 3, 0);
        sof_en = 1'b1;
        tick(3);
        clear_log();
        fire();
        tick(2);
        fire();
        fire();
        tick(200);
        check("R7", "merged pulse count with interval", rise_q.size(), 2);
        if (rise_q.size() == 2 && fall_q.size() >= 1) begin
            nsof = 0;
            last_tick = 1'b0;
            foreach (sof_q[i]) begin
                if (sof_q[i] >= fall_q[0] && sof_q[i] <= rise_q[1] - 1) nsof++;
                if (sof_q[i] == rise_q[1] - 2) last_tick = 1'b1;
            end
            check("R6", "ticks in interval", nsof, 3);
            check("R6", "pulse on edge after last tick", int'(last_tick), 1);
            check("R6", "pulse length", fall_q[0] - rise_q[0], 4);
        end

        // R9: clear during an open interval cancels the request
        cur_req = "R9";
        write_cfg(2, 5, 0);
        clear_log();
        fire();
        tick(8);
        fire();
        check("R9", "pending in interval", int'(pending_o), 1);
        clr = 1'b1;
        tick(1);
        clr = 1'b0;
        check("R9", "pending after clear", int'(pending_o), 0);
        tick(100);
        check("R9", "pulses after cleared request", rise_q.size(), 1);

        // R8, R9: level mode
        cur_req = "R8";
        lvl = 1'b1;
        tick(2);
        fire();
        check("R8", "level irq follows pending", int'(irq_o), 1);
        tick(100);
        check("R8", "level irq held across ticks", int'(irq_o), 1);
        cur_req = "R9";
        evt = 1'b1;
        clr = 1'b1;
        tick(1);
        evt = 1'b0;
        clr = 1'b0;
        check("R9", "set wins over clear", int'(pending_o), 1);
        clr = 1'b1;
        tick(1);
        clr = 1'b0;
        check("R8", "level irq after clear", int'(irq_o), 0);
        check("R9", "pending after level clear", int'(pending_o), 0);
        lvl = 1'b0;
        sof_en = 1'b0;
        tick(5);
        check("R1", "idle pin at end", int'(irq_o), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule